// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard control for a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and write-back. Conditional branches are resolved during decode. The block is purely combinational. It reads the register fields and write/load flags held in the four pipeline registers, and it reads the branch kind of the instruction now in decode. From these it produces four outputs:

- The mux selects for the two execute-stage operands.
- The mux selects for the two operands of the decode-stage branch comparison.
- One stall line.
- One flush line.

The surrounding pipeline acts on the two control lines. While stall is high it holds the PC and the fetch/decode register, and it forces the write and load controls entering the decode/execute register to zero, so that a bubble travels into execute. While flush is high it replaces the fetch/decode register with a no-op, which squashes the instruction fetched behind a taken branch.

The register file writes early in the cycle and reads late. A value retiring in write-back is therefore visible to a decode-stage read in the same cycle. Register index 31 is the hard-wired zero register and never creates a dependency. A zero-test branch (branch if zero, branch if non-zero) is decoded with its second source field set to 31, so it depends on one register only.

Top module: `hz_unit`

## Requirements
- R1: `alu_a_sel` is 2 when `exme_wr` is high and `exme_rd` equals `idex_rs1`. Otherwise it is 1 when `mewb_wr` is high and `mewb_rd` equals `idex_rs1`. Otherwise it is 0, which selects the register-file value.
- R2: When both the memory-stage producer and the write-back producer match the same source, the select is 2, because the younger producer wins.
- R3: `alu_b_sel` follows the rule of R1 with `idex_rs2` as the source. It is 0 whenever the matching producer's write flag is low.
- R4: Register index 31 never matches. A source or destination equal to 31 gives select 0 and never raises stall.
- R5: `stall` is 1 when `idex_ld` is high and `idex_rd` equals `ifid_rs1` or `ifid_rs2`. This is the load-use case.
- R6: With `id_br_kind` 2 (branch if zero) or 3 (branch if non-zero), `stall` is 1 when `idex_wr` is high and `idex_rd` equals `ifid_rs1` or `ifid_rs2`. This is the one-cycle wait behind an ALU producer.
- R7: With `id_br_kind` 2 or 3, `stall` is also 1 when `exme_ld` is high and `exme_rd` matches a decode source. This is the second wait cycle behind a load. With `id_br_kind` 0 the same condition does not stall.
- R8: `cmp_a_sel` and `cmp_b_sel` use the encoding and priority of R1 and R2, applied to `ifid_rs1` and `ifid_rs2` against the memory-stage and write-back-stage producers.
- R9: `flush_ifid` is 1 when the branch is taken and `stall` is 0. A branch is taken for kind 1 (always), for kind 2 with `id_br_zero` high, and for kind 3 with `id_br_zero` low.
- R10: For `id_br_kind` 0, an ALU producer in execute that matches a decode source does not raise `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs1 | input | REG_W | First source field of the instruction in decode |
| ifid_rs2 | input | REG_W | Second source field of the instruction in decode |
| id_br_kind | input | 2 | Branch kind in decode: 0 none, 1 always, 2 if zero, 3 if non-zero |
| id_br_zero | input | 1 | Compared operand is zero (from the external compare) |
| idex_rs1 | input | REG_W | First source field in execute |
| idex_rs2 | input | REG_W | Second source field in execute |
| idex_rd | input | REG_W | Destination field in execute |
| idex_wr | input | 1 | Execute-stage instruction writes a register |
| idex_ld | input | 1 | Execute-stage instruction is a load |
| exme_rd | input | REG_W | Destination field in memory stage |
| exme_wr | input | 1 | Memory-stage instruction writes a register |
| exme_ld | input | 1 | Memory-stage instruction is a load |
| mewb_rd | input | REG_W | Destination field in write-back |
| mewb_wr | input | 1 | Write-back instruction writes a register |
| alu_a_sel | output | 2 | Execute operand A select (0 file, 1 write-back, 2 memory stage) |
| alu_b_sel | output | 2 | Execute operand B select |
| cmp_a_sel | output | 2 | Decode compare operand A select |
| cmp_b_sel | output | 2 | Decode compare operand B select |
| stall | output | 1 | Hold PC and fetch/decode register; bubble into execute |
| flush_ifid | output | 1 | Squash the fetch/decode register |

## Verification
Every output is a function of the current stage fields alone, so each result is due in the same cycle as the stimulus. No register lies on the path. The bench applies a stage snapshot just after a rising edge and queues the expected selects and control lines. It compares them at the following falling edge, half a period later. Multi-cycle behaviour is not stored in the block. The load-then-branch and ALU-then-branch sequences are therefore played as consecutive snapshots, each showing the producer one stage further on, and the bench checks that stall lasts exactly as many snapshots as R5 to R7 require.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_WB  = 2'd1,
      SEL_MEM = 2'd2
   } fwd_sel_e;

   typedef enum logic [1:0] {
      BR_NONE   = 2'd0,
      BR_ALWAYS = 2'd1,
      BR_IFZERO = 2'd2,
      BR_IFNZ   = 2'd3
   } br_kind_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int REG_W    = 5,
   parameter int ZERO_IDX = 31,
   parameter bit HAS_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_IDX);

   generate
      if (HAS_ZERO) begin : g_zero
         assign hit = wr && (src == dst) && (dst != ZR);
      end else begin : g_plain
         assign hit = wr && (src == dst);
      end
   endgenerate
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
   import hz_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int ZERO_IDX = 31,
   parameter bit HAS_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wr,
   output logic [1:0]       sel
);
   logic     mem_hit;
   logic     wb_hit;
   fwd_sel_e pick;

   hz_src_match #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) mem_m (
      .src(src), .dst(mem_rd), .wr(mem_wr), .hit(mem_hit));
   hz_src_match #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) wb_m (
      .src(src), .dst(wb_rd), .wr(wb_wr), .hit(wb_hit));

   always_comb begin
      if (mem_hit)     pick = SEL_MEM;
      else if (wb_hit) pick = SEL_WB;
      else             pick = SEL_RF;
   end

   assign sel = pick;
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
   import hz_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int ZERO_IDX = 31,
   parameter bit HAS_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] ifid_rs1,
   input  logic [REG_W-1:0] ifid_rs2,
   input  logic [1:0]       br_kind,
   input  logic             br_zero,
   input  logic [REG_W-1:0] idex_rd,
   input  logic             idex_wr,
   input  logic             idex_ld,
   input  logic [REG_W-1:0] exme_rd,
   input  logic             exme_ld,
   output logic             stall,
   output logic             flush
);
   localparam int NSRC = 2;

   logic [REG_W-1:0] srcs [NSRC];
   logic [NSRC-1:0]  ld_ex_hit;
   logic [NSRC-1:0]  alu_ex_hit;
   logic [NSRC-1:0]  ld_me_hit;
   logic             is_cond;
   logic             taken;
   br_kind_e         kind;

   assign srcs[0] = ifid_rs1;
   assign srcs[1] = ifid_rs2;
   assign kind    = br_kind_e'(br_kind);

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         hz_src_match #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) ldx (
            .src(srcs[i]), .dst(idex_rd), .wr(idex_ld), .hit(ld_ex_hit[i]));
         hz_src_match #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) alx (
            .src(srcs[i]), .dst(idex_rd), .wr(idex_wr), .hit(alu_ex_hit[i]));
         hz_src_match #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) ldm (
            .src(srcs[i]), .dst(exme_rd), .wr(exme_ld), .hit(ld_me_hit[i]));
      end
   endgenerate

   always_comb begin
      is_cond = (kind == BR_IFZERO) || (kind == BR_IFNZ);
      unique case (kind)
         BR_ALWAYS: taken = 1'b1;
         BR_IFZERO: taken = br_zero;
         BR_IFNZ:   taken = !br_zero;
         default:   taken = 1'b0;
      endcase
      stall = (|ld_ex_hit) || (is_cond && ((|alu_ex_hit) || (|ld_me_hit)));
      flush = taken && !stall;
   end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
   parameter int REG_W    = 5,
   parameter int ZERO_IDX = 31,
   parameter bit HAS_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] ifid_rs1,
   input  logic [REG_W-1:0] ifid_rs2,
   input  logic [1:0]       id_br_kind,
   input  logic             id_br_zero,
   input  logic [REG_W-1:0] idex_rs1,
   input  logic [REG_W-1:0] idex_rs2,
   input  logic [REG_W-1:0] idex_rd,
   input  logic             idex_wr,
   input  logic             idex_ld,
   input  logic [REG_W-1:0] exme_rd,
   input  logic             exme_wr,
   input  logic             exme_ld,
   input  logic [REG_W-1:0] mewb_rd,
   input  logic             mewb_wr,
   output logic [1:0]       alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       cmp_a_sel,
   output logic [1:0]       cmp_b_sel,
   output logic             stall,
   output logic             flush_ifid
);
   localparam int NPICK = 4;

   initial begin
      assert (REG_W >= 1 && REG_W <= 16)
         else $error("hz_unit: REG_W out of range");
      assert (ZERO_IDX >= 0 && ZERO_IDX < (1 << REG_W))
         else $error("hz_unit: ZERO_IDX outside register space");
   end

   logic [REG_W-1:0] pick_src [NPICK];
   logic [1:0]       pick_sel [NPICK];

   assign pick_src[0] = idex_rs1;
   assign pick_src[1] = idex_rs2;
   assign pick_src[2] = ifid_rs1;
   assign pick_src[3] = ifid_rs2;

   generate
      for (genvar k = 0; k < NPICK; k++) begin : g_pick
         hz_fwd_pick #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) pick_i (
            .src   (pick_src[k]),
            .mem_rd(exme_rd),
            .mem_wr(exme_wr),
            .wb_rd (mewb_rd),
            .wb_wr (mewb_wr),
            .sel   (pick_sel[k]));
      end
   endgenerate

   assign alu_a_sel = pick_sel[0];
   assign alu_b_sel = pick_sel[1];
   assign cmp_a_sel = pick_sel[2];
   assign cmp_b_sel = pick_sel[3];

   hz_stall_ctl #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) stall_i (
      .ifid_rs1(ifid_rs1),
      .ifid_rs2(ifid_rs2),
      .br_kind (id_br_kind),
      .br_zero (id_br_zero),
      .idex_rd (idex_rd),
      .idex_wr (idex_wr),
      .idex_ld (idex_ld),
      .exme_rd (exme_rd),
      .exme_ld (exme_ld),
      .stall   (stall),
      .flush   (flush_ifid));
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
   parameter int REG_W    = 5,
   parameter int ZERO_IDX = 31,
   parameter bit HAS_ZERO = 1'b1
) (
   input logic [REG_W-1:0] ifid_rs1,
   input logic [REG_W-1:0] ifid_rs2,
   input logic [1:0]       id_br_kind,
   input logic             id_br_zero,
   input logic [REG_W-1:0] idex_rs1,
   input logic [REG_W-1:0] idex_rs2,
   input logic [REG_W-1:0] idex_rd,
   input logic             idex_wr,
   input logic             idex_ld,
   input logic [REG_W-1:0] exme_rd,
   input logic             exme_wr,
   input logic             exme_ld,
   input logic [REG_W-1:0] mewb_rd,
   input logic             mewb_wr,
   input logic [1:0]       alu_a_sel,
   input logic [1:0]       alu_b_sel,
   input logic [1:0]       cmp_a_sel,
   input logic [1:0]       cmp_b_sel,
   input logic             stall,
   input logic             flush_ifid
);
   localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_IDX);

   always_comb begin
      // R2: a matching memory-stage producer always wins on operand A
      if (exme_wr && exme_rd == idex_rs1 && !(HAS_ZERO && idex_rs1 == ZR))
         assert_mem_wins_R2: assert (alu_a_sel == 2'd2);
      // R3: operand B never picks write-back while its producer is silent
      if (!mewb_wr && !exme_wr)
         assert_b_idle_R3: assert (alu_b_sel == 2'd0);
      // R4: the zero register is never forwarded
      if (HAS_ZERO && idex_rs1 == ZR)
         assert_zero_nofwd_R4: assert (alu_a_sel == 2'd0);
      // R5: a load feeding a decode source holds the front end
      if (idex_ld && idex_rd != ZR && (idex_rd == ifid_rs1 || idex_rd == ifid_rs2))
         assert_load_use_R5: assert (stall);
      // R9: a stalled branch never squashes its successor
      assert_no_flush_in_stall_R9: assert (!(stall && flush_ifid));
      // R10: with no branch and no load in execute there is nothing to wait for
      if (id_br_kind == 2'd0 && !idex_ld)
         assert_plain_no_stall_R10: assert (!stall);
      // R8: compare selects take only the three defined codes
      assert_cmp_code_R8: assert (cmp_a_sel != 2'd3 && cmp_b_sel != 2'd3);
   end
endmodule

bind hz_unit hz_unit_chk #(.REG_W(REG_W), .ZERO_IDX(ZERO_IDX), .HAS_ZERO(HAS_ZERO)) chk_i (.*);

// File: tb/hz_unit_tb_top.sv
module hz_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 5;
   localparam int WDOG       = 5000;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [REG_W-1:0] ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd, exme_rd, mewb_rd;
   logic [1:0]       id_br_kind;
   logic             id_br_zero, idex_wr, idex_ld, exme_wr, exme_ld, mewb_wr;
   logic [1:0]       alu_a_sel, alu_b_sel, cmp_a_sel, cmp_b_sel;
   logic             stall, flush_ifid;

   hz_unit #(.REG_W(REG_W)) dut_i (.*);

   typedef struct {
      string      tag;
      logic [1:0] fa, fb, ca, cb;
      logic       st, fl;
   } exp_t;

   exp_t q[$];
   int   n_vec  = 0;
   int   n_bad  = 0;
   bit   done   = 1'b0;

   task automatic begin_vec();
      @(posedge clk);
      #1;
      ifid_rs1 = 5'd10; ifid_rs2 = 5'd11; id_br_kind = 2'd0; id_br_zero = 1'b0;
      idex_rs1 = 5'd12; idex_rs2 = 5'd13; idex_rd = 5'd20; idex_wr = 1'b0; idex_ld = 1'b0;
      exme_rd  = 5'd21; exme_wr  = 1'b0; exme_ld = 1'b0;
      mewb_rd  = 5'd22; mewb_wr  = 1'b0;
   endtask

   task automatic expect_out(string tag, logic [1:0] fa, logic [1:0] fb,
                             logic [1:0] ca, logic [1:0] cb, logic st, logic fl);
      exp_t e;
      e.tag = tag; e.fa = fa; e.fb = fb; e.ca = ca; e.cb = cb; e.st = st; e.fl = fl;
      q.push_back(e);
   endtask

   task automatic cmp1(string tag, string what, int act, int exp);
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: results are combinational, due half a period after the drive
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_vec++;
         cmp1(e.tag, "alu_a_sel", alu_a_sel, e.fa);
         cmp1(e.tag, "alu_b_sel", alu_b_sel, e.fb);
         cmp1(e.tag, "cmp_a_sel", cmp_a_sel, e.ca);
         cmp1(e.tag, "cmp_b_sel", cmp_b_sel, e.cb);
         cmp1(e.tag, "stall", stall, e.st);
         cmp1(e.tag, "flush_ifid", flush_ifid, e.fl);
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // idle snapshot (R1 baseline)
      begin_vec(); expect_out("R1 idle", 0, 0, 0, 0, 0, 0);
      // R1: ADD x12 in memory stage feeding ADDI in execute
      begin_vec(); exme_wr = 1; exme_rd = 12; expect_out("R1 mem", 2, 0, 0, 0, 0, 0);
      begin_vec(); mewb_wr = 1; mewb_rd = 12; expect_out("R1 wb", 1, 0, 0, 0, 0, 0);
      // R2: both match
      begin_vec(); exme_wr = 1; exme_rd = 12; mewb_wr = 1; mewb_rd = 12;
      expect_out("R2 prio", 2, 0, 0, 0, 0, 0);
      // R3: operand B
      begin_vec(); exme_wr = 1; exme_rd = 13; mewb_wr = 1; mewb_rd = 12;
      expect_out("R3 b mem", 1, 2, 0, 0, 0, 0);
      begin_vec(); exme_wr = 0; exme_rd = 13; expect_out("R3 no wr", 0, 0, 0, 0, 0, 0);
      // R4: zero register everywhere
      begin_vec(); ifid_rs1 = 31; idex_rs1 = 31; idex_rd = 31; idex_wr = 1; idex_ld = 1;
      exme_rd = 31; exme_wr = 1; mewb_rd = 31; mewb_wr = 1; id_br_kind = 2;
      expect_out("R4 zero", 0, 0, 0, 0, 0, 0);
      // R5: load then use
      begin_vec(); idex_ld = 1; idex_wr = 1; idex_rd = 11; expect_out("R5 rs2", 0, 0, 0, 0, 1, 0);
      begin_vec(); idex_ld = 1; idex_wr = 1; idex_rd = 10; expect_out("R5 rs1", 0, 0, 0, 0, 1, 0);
      // R5: stall gone once the load leaves execute
      begin_vec(); exme_ld = 1; exme_wr = 1; exme_rd = 10; expect_out("R5 release", 0, 0, 2, 0, 0, 0);
      // R10: ALU producer, no branch
      begin_vec(); idex_wr = 1; idex_rd = 10; expect_out("R10", 0, 0, 0, 0, 0, 0);
      // R6: ADD then CBZ, one stall
      begin_vec(); idex_wr = 1; idex_rd = 10; ifid_rs2 = 31; id_br_kind = 2; id_br_zero = 1;
      expect_out("R6 alu", 0, 0, 0, 0, 1, 0);
      begin_vec(); exme_wr = 1; exme_rd = 10; ifid_rs2 = 31; id_br_kind = 2; id_br_zero = 1;
      expect_out("R8 R9 after alu", 0, 0, 2, 0, 0, 1);
      // R7: LDR then CBNZ, two stalls then forward from write-back
      begin_vec(); idex_ld = 1; idex_wr = 1; idex_rd = 10; ifid_rs2 = 31; id_br_kind = 3;
      expect_out("R7 cyc1", 0, 0, 0, 0, 1, 0);
      begin_vec(); exme_ld = 1; exme_wr = 1; exme_rd = 10; ifid_rs2 = 31; id_br_kind = 3;
      expect_out("R7 cyc2", 0, 0, 2, 0, 1, 0);
      begin_vec(); mewb_wr = 1; mewb_rd = 10; ifid_rs2 = 31; id_br_kind = 3;
      expect_out("R7 R9 cyc3", 0, 0, 1, 0, 0, 1);
      // R8: two compare operands, mixed sources
      begin_vec(); mewb_wr = 1; mewb_rd = 10; exme_wr = 1; exme_rd = 11;
      expect_out("R8 mixed", 0, 0, 1, 2, 0, 0);
      // R9: branch kinds
      begin_vec(); id_br_kind = 1; expect_out("R9 always", 0, 0, 0, 0, 0, 1);
      begin_vec(); id_br_kind = 2; id_br_zero = 0; expect_out("R9 cbz nt", 0, 0, 0, 0, 0, 0);
      begin_vec(); id_br_kind = 3; id_br_zero = 1; expect_out("R9 cbnz nt", 0, 0, 0, 0, 0, 0);
      begin_vec(); id_br_kind = 1; idex_ld = 1; idex_rd = 10;
      expect_out("R9 stalled", 0, 0, 0, 0, 1, 0);
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule